// File: doc/BRIEF.md
# Routable Two-Bank Interrupt Controller

The block gathers 32 level-sensitive interrupt sources, arranged as two banks of sixteen. Each bank has a live status view of its source levels and a software-written enable mask. A source takes part in arbitration only while its level is high and its mask bit is set. Every source is steered to one of five CPU interrupt lines. For most sources the line comes from a 3-bit routing field. Those fields are packed unevenly into four routing registers. The few sources that have no field keep a fixed line.

For each CPU line, a combinational arbiter picks one winner among the enabled, pending sources routed to that line. The line is asserted while a winner exists. A read-only claim register reports which source won. Software reaches all of this through a plain 16-bit register port with two windows and halfword offsets. Reads are combinational. Writes take effect on the next clock edge. No part of the block carries a data stream, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `intc_route`

## Requirements
- R1: Reading status (window 0 offset 0x00 for bank 1, window 1 offset 0x00 for bank 2) returns the current source levels. A source counts toward a CPU line only while both its level and its mask bit are 1. The bank 1 mask is at window 0 offset 0x0C, and the bank 2 mask is at window 1 offset 0x06.
- R2: Both masks reset to 0x0000, so no CPU line is asserted after reset, whatever the source levels.
- R3: Bank 1 routing fields are 3 bits wide, and a field value v steers the source to CPU line v. Register A (window 0, offset 0x04) holds source 0 at bits 2:0, source 1 at bits 5:3, source 2 at bits 8:6, source 3 at bits 11:9 and source 8 at bits 14:12. Register B (window 0, offset 0x06) holds source 9 at bits 2:0, source 11 at bits 8:6 and source 12 at bits 11:9.
- R4: Bank 2 fields live in window 0. Register C (offset 0x1C) holds sources 0, 1, 3, 4 and 5, and register D (offset 0x1E) holds sources 6, 7, 8, 9 and 10. In both registers the five fields sit at bits 2:0, 5:3, 8:6, 11:9 and 14:12, in ascending source order.
- R5: After reset, register A reads 0x0040 (bank 1 source 2 on line 1) and register C reads 0x0002 (bank 2 source 0 on line 2). Registers B and D read 0x0000.
- R6: In a register write, a field whose new value is 5, 6 or 7 keeps its old value. The legal fields of that same write still update.
- R7: Routing-register bits outside any field read as 0 and ignore writes. A source without a field has a fixed route: bank 2 source 2 goes to line 3, and every other such source goes to line 0.
- R8: When several enabled, pending sources share a line, any bank 1 source beats any bank 2 source. Within a bank, the lowest source index wins.
- R9: Line k's claim register sits at window 1 offset 0x10+2k. It reads bit 5 = valid, bit 4 = bank (0 for bank 1), bits 3:0 = source index, and zero when no source is claimed. Unmapped offsets read 0, and offset bit 0 is ignored.
- R10: A write updates its register at the next rising clock edge. Before that edge, a read of the same register returns the old value; after it, the new value.
- R11: CPU line k is high exactly when its claim register is valid, and it follows source and mask changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_b1 | input | 16 | Bank 1 source levels, already synchronised |
| irq_b2 | input | 16 | Bank 2 source levels, already synchronised |
| reg_win | input | 1 | Register window select: 0 for bank 1 and routing, 1 for bank 2 and claims |
| reg_off | input | 5 | Byte offset inside the window (halfword aligned) |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| cpu_irq | output | 5 | CPU interrupt lines |

## Verification
Two functions can fall in one cycle: a register write that is waiting for its clock edge, and a change on a source level, which acts combinationally. The bench drives a mask write together with a new source level in the same cycle. It then checks that the line rises at once under the old mask and drops right after the edge, when the new mask takes hold. A behavioural model recomputes every line on each clock, so any skew between the registered and combinational paths shows up as a mismatch. Routing writes that mix legal and illegal field values are judged by reading the register back.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_SRC = 16;
  localparam int N_RTREG  = 4;
  localparam int N_SLOT   = 5;

  typedef struct packed {
    logic       vld;
    logic       bank;
    logic [3:0] idx;
  } claim_t;

  // Routing register holding a source's field: 0=A 1=B 2=C 3=D, -1 = none
  function automatic int fld_reg(int bank, int src);
    if (bank == 0) begin
      case (src)
        0, 1, 2, 3, 8: return 0;
        9, 11, 12:     return 1;
        default:       return -1;
      endcase
    end
    case (src)
      0, 1, 3, 4, 5:   return 2;
      6, 7, 8, 9, 10:  return 3;
      default:         return -1;
    endcase
  endfunction

  // Lowest bit of a source's field inside its routing register
  function automatic int fld_pos(int bank, int src);
    if (bank == 0) begin
      case (src)
        1, 11:   return 3 * (src == 1 ? 1 : 2);
        2:       return 6;
        3, 12:   return 9;
        8:       return 12;
        default: return 0;
      endcase
    end
    case (src)
      1:       return 3;
      3:       return 6;
      4:       return 9;
      5:       return 12;
      6, 7, 8, 9, 10: return (src - 6) * 3;
      default: return 0;
    endcase
  endfunction

  // Route after reset (and permanent route of sources without a field)
  function automatic int rst_route(int bank, int src);
    if (bank == 0 && src == 2) return 1;
    if (bank == 1 && src == 0) return 2;
    if (bank == 1 && src == 2) return 3;
    return 0;
  endfunction

  // Source occupying slot k of routing register r, -1 if the slot is a gap
  function automatic int slot_src(int r, int k);
    for (int s = 0; s < BANK_SRC; s++)
      if (fld_reg(r / 2, s) == r && fld_pos(r / 2, s) == 3 * k) return s;
    return -1;
  endfunction
endpackage

// File: rtl/intc_asgn.sv
module intc_asgn
  import intc_pkg::*;
#(
  parameter int RW    = 16,
  parameter int FW    = 3,
  parameter int NREG  = N_RTREG,
  parameter int NSLOT = N_SLOT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           wr_sel,
  input  logic [RW-1:0]             wdata,
  output logic [NREG-1:0][RW-1:0]   asg
);
  localparam int LEGAL_MAX = 4;
  localparam int USED_W    = NSLOT * FW;

  logic unused_hi;
  assign unused_hi = ^wdata[RW-1:USED_W];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (USED_W < RW) begin : g_top
      assign asg[r][RW-1:USED_W] = '0;
    end
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam int SRC = slot_src(r, k);
      if (SRC >= 0) begin : g_fld
        logic [FW-1:0] fld_q;
        logic [FW-1:0] nv;
        assign nv = wdata[k*FW +: FW];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                  fld_q <= FW'(rst_route(r / 2, SRC));
          else if (wr_sel[r] && nv <= FW'(LEGAL_MAX))  fld_q <= nv;
        end
        assign asg[r][k*FW +: FW] = fld_q;

        p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_sel[r] && wdata[k*FW +: FW] > FW'(LEGAL_MAX)) |=> $stable(asg[r][k*FW +: FW]));
        p_field_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
          asg[r][k*FW +: FW] <= FW'(LEGAL_MAX));
      end else begin : g_gap
        assign asg[r][k*FW +: FW] = '0;
      end
    end
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int N_SRC  = BANK_SRC,
  parameter int FW     = 3,
  parameter int OUT_ID = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           act1,
  input  logic [N_SRC-1:0]           act2,
  input  logic [N_SRC-1:0][FW-1:0]   rt1,
  input  logic [N_SRC-1:0][FW-1:0]   rt2,
  output claim_t                     claim
);
  logic [N_SRC-1:0] hit1, hit2;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      hit1[i] = act1[i] && (rt1[i] == FW'(OUT_ID));
      hit2[i] = act2[i] && (rt2[i] == FW'(OUT_ID));
    end
  end

  // Later assignments override earlier ones: bank 1, lowest index, wins.
  always_comb begin
    claim = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (hit2[i]) claim = '{vld: 1'b1, bank: 1'b1, idx: 4'(i)};
    for (int i = N_SRC - 1; i >= 0; i--)
      if (hit1[i]) claim = '{vld: 1'b1, bank: 1'b0, idx: 4'(i)};
  end

  p_claim_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim.vld |-> (claim.bank ? (act2[claim.idx] && rt2[claim.idx] == FW'(OUT_ID))
                              : (act1[claim.idx] && rt1[claim.idx] == FW'(OUT_ID))));
  p_bank_pri_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim.vld && claim.bank) |-> (hit1 == '0));
  p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim.vld && !claim.bank) |-> ((hit1 & ((N_SRC'(1) << claim.idx) - N_SRC'(1))) == '0));
endmodule

// File: rtl/intc_route.sv
module intc_route
  import intc_pkg::*;
#(
  parameter int N_SRC = BANK_SRC,
  parameter int N_OUT = 5,
  parameter int RW    = 16,
  parameter int FW    = 3,
  parameter int AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_b1,
  input  logic [N_SRC-1:0]  irq_b2,
  input  logic              reg_win,
  input  logic [AW-1:0]     reg_off,
  input  logic              reg_wr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic [N_OUT-1:0]  cpu_irq
);
  localparam int IW = AW - 1;
  localparam int CW = $bits(claim_t);
  // halfword indices (offset / 2)
  localparam logic [IW-1:0] H_STAT  = IW'(0);
  localparam logic [IW-1:0] H_RTA   = IW'(2);
  localparam logic [IW-1:0] H_RTB   = IW'(3);
  localparam logic [IW-1:0] H_MSK1  = IW'(6);
  localparam logic [IW-1:0] H_RTC   = IW'(14);
  localparam logic [IW-1:0] H_RTD   = IW'(15);
  localparam logic [IW-1:0] H_MSK2  = IW'(3);
  localparam int            H_CLM0  = 8;

  logic [IW-1:0] hidx;
  logic          unused_lsb;
  assign hidx       = reg_off[AW-1:1];
  assign unused_lsb = reg_off[0];

  logic [N_SRC-1:0] mask1_q, mask2_q;
  logic [N_RTREG-1:0] rt_wr;
  logic [N_RTREG-1:0][RW-1:0] asg;
  logic [N_SRC-1:0][FW-1:0] rt1, rt2;
  claim_t claim [N_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1_q <= '0;
      mask2_q <= '0;
    end else if (reg_wr) begin
      if (!reg_win && hidx == H_MSK1) mask1_q <= reg_wdata[N_SRC-1:0];
      if ( reg_win && hidx == H_MSK2) mask2_q <= reg_wdata[N_SRC-1:0];
    end
  end

  assign rt_wr[0] = reg_wr && !reg_win && hidx == H_RTA;
  assign rt_wr[1] = reg_wr && !reg_win && hidx == H_RTB;
  assign rt_wr[2] = reg_wr && !reg_win && hidx == H_RTC;
  assign rt_wr[3] = reg_wr && !reg_win && hidx == H_RTD;

  intc_asgn #(.RW(RW), .FW(FW), .NREG(N_RTREG), .NSLOT(N_SLOT)) i_asgn (
    .clk(clk), .rst_n(rst_n), .wr_sel(rt_wr), .wdata(reg_wdata), .asg(asg));

  for (genvar s = 0; s < N_SRC; s++) begin : g_rt
    localparam int R1 = fld_reg(0, s);
    localparam int R2 = fld_reg(1, s);
    if (R1 >= 0) begin : g_f1
      assign rt1[s] = asg[R1][fld_pos(0, s) +: FW];
    end else begin : g_x1
      assign rt1[s] = FW'(rst_route(0, s));
    end
    if (R2 >= 0) begin : g_f2
      assign rt2[s] = asg[R2][fld_pos(1, s) +: FW];
    end else begin : g_x2
      assign rt2[s] = FW'(rst_route(1, s));
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    intc_pick #(.N_SRC(N_SRC), .FW(FW), .OUT_ID(o)) i_pick (
      .clk(clk), .rst_n(rst_n),
      .act1(irq_b1 & mask1_q), .act2(irq_b2 & mask2_q),
      .rt1(rt1), .rt2(rt2), .claim(claim[o]));
    assign cpu_irq[o] = claim[o].vld;
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_win) begin
      case (hidx)
        H_STAT: reg_rdata = RW'(irq_b1);
        H_RTA:  reg_rdata = asg[0];
        H_RTB:  reg_rdata = asg[1];
        H_MSK1: reg_rdata = RW'(mask1_q);
        H_RTC:  reg_rdata = asg[2];
        H_RTD:  reg_rdata = asg[3];
        default: reg_rdata = '0;
      endcase
    end else begin
      if (hidx == H_STAT) reg_rdata = RW'(irq_b2);
      if (hidx == H_MSK2) reg_rdata = RW'(mask2_q);
      for (int o = 0; o < N_OUT; o++)
        if (hidx == IW'(H_CLM0 + o)) reg_rdata = {{(RW-CW){1'b0}}, claim[o]};
    end
  end

  p_mask_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask1_q == '0 && mask2_q == '0 && cpu_irq == '0));
  p_wr_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_win && hidx == H_MSK1) |=> (mask1_q == $past(reg_wdata[N_SRC-1:0])));
  p_gap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_win && hidx == H_RTB) |-> (reg_rdata[5:3] == '0 && reg_rdata[RW-1:12] == '0));
  p_irq_needs_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq != '0) |-> (((irq_b1 & mask1_q) | (irq_b2 & mask2_q)) != '0));
endmodule

// File: tb/test_intc_route.sv
`timescale 1ns/100ps
module test_intc_route;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] lv1 = 16'hFFFF, lv2 = 16'hFFFF;
  logic win = 1'b0, wr = 1'b0;
  logic [4:0] off = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0] irq;
  logic run = 1'b0;

  int errs = 0, checks = 0;
  int rt1 [16], rt2 [16];
  logic [15:0] m1, m2;

  always #2 clk = ~clk;

  intc_route i_intc_route (
    .clk(clk), .rst_n(rst_n), .irq_b1(lv1), .irq_b2(lv2),
    .reg_win(win), .reg_off(off), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .cpu_irq(irq));

  // Field table taken from R3/R4: register 0..3 = A..D, -1 = no field
  function automatic int t_reg(int b, int s);
    if (b == 0) return (s <= 3 || s == 8) ? 0 : (s == 9 || s == 11 || s == 12) ? 1 : -1;
    return (s <= 1 || (s >= 3 && s <= 5)) ? 2 : (s >= 6 && s <= 10) ? 3 : -1;
  endfunction
  function automatic int t_pos(int b, int s);
    if (b == 0) begin
      if (s == 8) return 12;
      if (s == 9) return 0;
      if (s == 11) return 6;
      if (s == 12) return 9;
      return 3 * s;
    end
    if (s <= 1) return 3 * s;
    if (s <= 5) return 3 * (s - 1);
    return 3 * (s - 6);
  endfunction

  function automatic logic [15:0] asg_exp(int r);
    logic [15:0] v = '0;
    for (int s = 0; s < 16; s++)
      if (t_reg(r / 2, s) == r) v |= 16'(((r < 2) ? rt1[s] : rt2[s]) << t_pos(r / 2, s));
    return v;
  endfunction

  function automatic logic [15:0] claim_exp(int o);
    for (int s = 0; s < 16; s++)
      if (lv1[s] && m1[s] && rt1[s] == o) return 16'h20 | 16'(s);
    for (int s = 0; s < 16; s++)
      if (lv2[s] && m2[s] && rt2[s] == o) return 16'h30 | 16'(s);
    return 16'h0;
  endfunction

  function automatic logic [4:0] irq_exp();
    logic [4:0] v;
    for (int o = 0; o < 5; o++) v[o] = claim_exp(o)[5];
    return v;
  endfunction

  function automatic logic [15:0] rd_exp(logic w, int a);
    if (!w) begin
      case (a)
        'h00: return lv1;
        'h04: return asg_exp(0);
        'h06: return asg_exp(1);
        'h0C: return m1;
        'h1C: return asg_exp(2);
        'h1E: return asg_exp(3);
        default: return 16'h0;
      endcase
    end
    if (a == 'h00) return lv2;
    if (a == 'h06) return m2;
    for (int o = 0; o < 5; o++) if (a == 'h10 + 2 * o) return claim_exp(o);
    return 16'h0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 16; s++) begin rt1[s] = 0; rt2[s] = 0; end
    rt1[2] = 1; rt2[0] = 2; rt2[2] = 3;
    m1 = '0; m2 = '0;
  endtask

  task automatic model_write(logic w, int a, logic [15:0] d);
    int r;
    if (w) begin
      if (a == 'h06) m2 = d;
      return;
    end
    r = (a == 'h04) ? 0 : (a == 'h06) ? 1 : (a == 'h1C) ? 2 : (a == 'h1E) ? 3 : -1;
    if (a == 'h0C) m1 = d;
    if (r < 0) return;
    for (int s = 0; s < 16; s++) begin
      if (t_reg(r / 2, s) == r) begin
        int v = int'((d >> t_pos(r / 2, s)) & 16'h7);
        if (v <= 4) begin
          if (r < 2) rt1[s] = v; else rt2[s] = v;
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic w, int a, string tag);
    @(negedge clk); #0.5;
    win = w; off = 5'(a);
    #0.5 chk(tag, rdata, rd_exp(w, a));
  endtask

  task automatic rd_lit(logic w, int a, logic [15:0] exp, string tag);
    @(negedge clk); #0.5;
    win = w; off = 5'(a);
    #0.5 chk(tag, rdata, exp);
  endtask

  task automatic wrt(logic w, int a, logic [15:0] d, string tag);
    @(negedge clk); #0.5;
    win = w; off = 5'(a); wdata = d; wr = 1'b1;
    #0.5 chk("R10 pre-edge", rdata, rd_exp(w, a));
    @(posedge clk); #0.5;
    wr = 1'b0;
    model_write(w, a, d);
    #0.5 chk(tag, rdata, rd_exp(w, a));
  endtask

  task automatic set_lv(logic [15:0] a, logic [15:0] b);
    @(negedge clk); #0.5;
    lv1 = a; lv2 = b;
  endtask

  task automatic chk_irq(logic [4:0] exp, string tag);
    @(negedge clk); #0.5;
    chk(tag, 16'(irq), 16'(exp));
  endtask

  // Reference comparison on every clock (R11)
  always @(negedge clk) begin
    if (run) chk("R11 per-cycle line", 16'(irq), 16'(irq_exp()));
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    run = 1'b1;
    // reset state
    chk_irq(5'b00000, "R2 no line with all sources high");
    rd_lit(0, 'h0C, 16'h0000, "R2 mask1 reset");
    rd_lit(1, 'h06, 16'h0000, "R2 mask2 reset");
    rd_lit(0, 'h04, 16'h0040, "R5 reg A reset");
    rd_lit(0, 'h1C, 16'h0002, "R5 reg C reset");
    rd_lit(0, 'h06, 16'h0000, "R5 reg B reset");
    rd_lit(0, 'h1E, 16'h0000, "R5 reg D reset");
    rd_lit(0, 'h00, 16'hFFFF, "R1 status1");
    // reset routes
    set_lv(16'h0004, 16'h0005);
    wrt(0, 'h0C, 16'hFFFF, "R1 mask1 write");
    chk_irq(5'b00010, "R5 b1 s2 on line 1");
    wrt(1, 'h06, 16'hFFFF, "R1 mask2 write");
    chk_irq(5'b01110, "R5 b2 s0 line 2, R7 b2 s2 line 3");
    rd_lit(1, 'h16, 16'h0032, "R9 claim line 3");
    rd_lit(1, 'h12, 16'h0022, "R9 claim line 1");
    rd_lit(1, 'h01, 16'h0005, "R9 offset bit 0 ignored");
    // bank 1 layout
    wrt(0, 'h04, 16'h029C, "R3 reg A write");
    rd_lit(0, 'h04, 16'h029C, "R3 reg A readback");
    set_lv(16'h0001, 16'h0000);
    chk_irq(5'b10000, "R3 b1 s0 on line 4");
    set_lv(16'h0100, 16'h0000);
    chk_irq(5'b00001, "R3 b1 s8 on line 0");
    wrt(0, 'h06, 16'h88B9, "R7 reg B gap write");
    rd_lit(0, 'h06, 16'h0881, "R7 reg B gaps read zero");
    set_lv(16'h1000, 16'h0000);
    chk_irq(5'b10000, "R3 b1 s12 on line 4");
    // illegal values
    wrt(0, 'h04, 16'h528F, "R6 mixed write");
    rd_lit(0, 'h04, 16'h028C, "R6 illegal fields kept");
    // bank 2 layout
    wrt(0, 'h1C, 16'h4921, "R4 reg C write");
    wrt(0, 'h1E, 16'h4688, "R4 reg D write");
    rd_lit(0, 'h1E, 16'h4688, "R4 reg D readback");
    set_lv(16'h0000, 16'h0400);
    chk_irq(5'b10000, "R4 b2 s10 on line 4");
    set_lv(16'h0000, 16'h0002);
    chk_irq(5'b10000, "R4 b2 s1 on line 4");
    set_lv(16'h0000, 16'h0004);
    chk_irq(5'b01000, "R7 b2 s2 fixed line 3");
    // priority
    set_lv(16'h1000, 16'h0018);
    rd_lit(1, 'h18, 16'h002C, "R8 bank 1 beats bank 2");
    set_lv(16'h0000, 16'h0018);
    rd_lit(1, 'h18, 16'h0033, "R8 lowest in bank 2");
    set_lv(16'h0208, 16'h0000);
    rd_lit(1, 'h12, 16'h0023, "R8 lowest in bank 1");
    // masking
    wrt(0, 'h0C, 16'hFFF7, "R1 mask1 clear bit 3");
    rd_lit(1, 'h12, 16'h0029, "R1 masked source skipped");
    rd_lit(0, 'h00, 16'h0208, "R1 status shows masked level");
    rd_lit(0, 'h02, 16'h0000, "R9 unmapped window 0");
    rd_lit(1, 'h1E, 16'h0000, "R9 unmapped window 1");
    // same cycle: mask write pending while a source rises
    @(negedge clk); #0.5;
    lv1 = 16'h0001; lv2 = 16'h0000;
    win = 1'b0; off = 5'h0C; wdata = 16'h0000; wr = 1'b1;
    #0.5 chk("R10 line rises under old mask", 16'(irq), 16'h0010);
    @(posedge clk); #0.5;
    wr = 1'b0;
    model_write(0, 'h0C, 16'h0000);
    #0.5 chk("R10 line drops after edge", 16'(irq), 16'h0000);
    rd(1, 'h18, "R9 claim cleared");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule